// File: doc/BRIEF.md
# Hot-Plug Slot Fault Supervisor

This block watches two independently powered card slots. For each slot it decides whether the auxiliary supply and the main supply may be switched on, and it latches a slot fault when an electrical or thermal hazard shows up while that slot is in use. Analog comparators, current sensing and gate drivers sit outside the block. Their decisions arrive as single-bit inputs that are already synchronous to `clk`. The block drives a registered enable for each supply of each slot, an active-low fault per slot and one shared active-low interrupt.

After reset, a start-up timer runs for `POR_CYCLES` clocks, and nothing is enabled or faulted until it expires. A slot's fault condition combines five terms:
- undervoltage on any of the slot's rails;
- a fast overcurrent trip;
- a slow overcurrent trip that has persisted through a per-slot filter window;
- a slow overcurrent trip while the slot is hot;
- a global over-temperature flag.

Once latched, a fault holds until software or the host withdraws both requests of that slot. The interrupt stays asserted until it is acknowledged.

Top module: `hp_slot_supervisor`

## Requirements
- R1: A slot's fault output (`fault_n[s]` low) can only be set in a clock edge where that slot's `aux_req[s]` or `main_req[s]` is high. With both requests low at an edge, the fault is clear after that edge.
- R2: Any rail undervoltage bit of a slot sets that slot's fault on the next edge. Bit `s*RAILS+r` of `rail_uv` belongs to slot `s`, rail `r`.
- R3: A high `oc_fast[s]` sets that slot's fault on the next edge.
- R4: When `oc_slow[s]` is sampled high on `FILT_CYCLES` consecutive edges, the fault is set on the following edge, which is edge `FILT_CYCLES+1`. A single low sample of `oc_slow[s]` restarts the full window.
- R5: `oc_slow[s]` and `slot_hot[s]` high together set the fault on the next edge, with no filter delay.
- R6: `die_hot` sets the fault on the next edge in every slot that has a request active.
- R7: A set fault stays set while either request of that slot stays high, even after every condition clears.
- R8: `por_done` rises on the `POR_CYCLES`-th edge after reset release. Before that, no fault and no enable is driven. A fault can first be set on the edge after `por_done` is high.
- R9: `aux_en[s]` turns on only after `aux_req[s]` has been sampled low while `por_done` is high. After that, `aux_en[s]` follows `aux_req[s]` one edge later.
- R10: `main_en[s]` is high one edge after `main_req[s]` is sampled high, provided `por_done` is high and no rail of the slot is undervoltage.
- R11: On the edge where a slot's fault sets, and for as long as it stays set, both enables of that slot are low.
- R12: `int_n` goes low on the same edge as any slot's fault sets. It returns high on an edge where `int_ack` is high and no new fault sets; a new fault takes priority over the acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aux_req | input | NUM_SLOTS | Auxiliary supply request per slot |
| main_req | input | NUM_SLOTS | Main supply request per slot |
| rail_uv | input | NUM_SLOTS*RAILS | Undervoltage flags, slot-major |
| oc_fast | input | NUM_SLOTS | Fast overcurrent trip per slot |
| oc_slow | input | NUM_SLOTS | Slow overcurrent trip per slot |
| slot_hot | input | NUM_SLOTS | Slot over-temperature flag |
| die_hot | input | 1 | Global over-temperature flag |
| int_ack | input | 1 | Software interrupt acknowledge |
| aux_en | output | NUM_SLOTS | Auxiliary supply enable |
| main_en | output | NUM_SLOTS | Main supply enable |
| fault_n | output | NUM_SLOTS | Active-low latched slot fault |
| int_n | output | 1 | Active-low interrupt |
| por_done | output | 1 | Start-up delay elapsed |

## Verification
Directed sequences apply each fault term on its own, so a term that is missing from the OR, or routed to the wrong slot, shows up alone.

The slow trip is held for exactly the window length, and then one edge longer. It is also broken for one cycle near expiry, which separates an off-by-one or a missing reload from correct filtering.

An auxiliary request held through the start-up delay and a request raised after it tell apart correct arming from a plain level gate. Seeded random stimulus on requests, trips, acknowledges and rails then exercises interactions between slots and the priority between a new interrupt and its acknowledge.

// File: rtl/hps_pkg.sv
package hps_pkg;

    typedef struct packed {
        logic uv;
        logic fast;
        logic slow_expired;
        logic slow_hot;
        logic glob_hot;
    } slot_cond_t;

    function automatic logic cond_any(input slot_cond_t c);
        return c.uv | c.fast | c.slow_expired | c.slow_hot | c.glob_hot;
    endfunction

endpackage

// File: rtl/hps_por_timer.sv
module hps_por_timer #(
    parameter int POR_CYCLES = 25000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int POR_W = $clog2(POR_CYCLES + 1);

    typedef struct packed {
        logic [POR_W-1:0] cnt;
        logic             done;
    } por_state_t;

    por_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.done) begin
            st_d.cnt  = st_q.cnt + POR_W'(1);
            st_d.done = (st_q.cnt == POR_W'(POR_CYCLES - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;

    p_por_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
endmodule

// File: rtl/hps_slow_filter.sv
module hps_slow_filter #(
    parameter int FILT_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    output logic expired
);
    localparam int FW = $clog2(FILT_CYCLES + 1);
    localparam logic [FW-1:0] LOAD = FW'(FILT_CYCLES);

    logic [FW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!trip)              cnt_d = LOAD;
        else if (cnt_q != '0)   cnt_d = cnt_q - FW'(1);
        else                    cnt_d = '0;
        expired = trip && (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= LOAD;
        else        cnt_q <= cnt_d;
    end

    p_no_instant_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip) |-> !expired);
endmodule

// File: rtl/hps_slot_ctrl.sv
module hps_slot_ctrl
    import hps_pkg::*;
#(
    parameter int RAILS       = 5,
    parameter int FILT_CYCLES = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_done,
    input  logic             aux_req,
    input  logic             main_req,
    input  logic [RAILS-1:0] rail_uv,
    input  logic             oc_fast,
    input  logic             oc_slow,
    input  logic             slot_hot,
    input  logic             die_hot,
    output logic             fault,
    output logic             fault_rise,
    output logic             aux_en,
    output logic             main_en
);
    typedef struct packed {
        logic fault;
        logic armed;
        logic aux_en;
        logic main_en;
    } slot_state_t;

    slot_state_t st_d, st_q;
    slot_cond_t  cond;
    logic        slow_expired;
    logic        active;

    hps_slow_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .trip    (oc_slow),
        .expired (slow_expired)
    );

    always_comb begin
        cond.uv           = |rail_uv;
        cond.fast         = oc_fast;
        cond.slow_expired = slow_expired;
        cond.slow_hot     = oc_slow & slot_hot;
        cond.glob_hot     = die_hot;
        active            = aux_req | main_req;

        st_d.fault   = active & por_done & (st_q.fault | cond_any(cond));
        st_d.armed   = st_q.armed | (por_done & ~aux_req);
        st_d.aux_en  = aux_req & st_q.armed & ~st_d.fault;
        st_d.main_en = main_req & por_done & ~cond.uv & ~st_d.fault;
        fault_rise   = st_d.fault & ~st_q.fault;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fault   = st_q.fault;
    assign aux_en  = st_q.aux_en;
    assign main_en = st_q.main_en;

    p_fault_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(aux_req | main_req) |=> !fault);
    p_fault_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault && (aux_req | main_req) |=> fault);
    p_quiet_before_por_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !por_done |-> !fault && !aux_en && !main_en);
    p_fault_kills_supply_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !aux_en && !main_en);
    p_fast_trip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        por_done && oc_fast && (aux_req | main_req) |=> fault);
endmodule

// File: rtl/hp_slot_supervisor.sv
module hp_slot_supervisor #(
    parameter int NUM_SLOTS   = 2,
    parameter int RAILS       = 5,
    parameter int POR_CYCLES  = 25000,
    parameter int FILT_CYCLES = 1000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SLOTS-1:0]       aux_req,
    input  logic [NUM_SLOTS-1:0]       main_req,
    input  logic [NUM_SLOTS*RAILS-1:0] rail_uv,
    input  logic [NUM_SLOTS-1:0]       oc_fast,
    input  logic [NUM_SLOTS-1:0]       oc_slow,
    input  logic [NUM_SLOTS-1:0]       slot_hot,
    input  logic                       die_hot,
    input  logic                       int_ack,
    output logic [NUM_SLOTS-1:0]       aux_en,
    output logic [NUM_SLOTS-1:0]       main_en,
    output logic [NUM_SLOTS-1:0]       fault_n,
    output logic                       int_n,
    output logic                       por_done
);
    logic [NUM_SLOTS-1:0] fault;
    logic [NUM_SLOTS-1:0] fault_rise;
    logic                 int_d, int_q;

    hps_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (por_done)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        hps_slot_ctrl #(.RAILS(RAILS), .FILT_CYCLES(FILT_CYCLES)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .por_done   (por_done),
            .aux_req    (aux_req[s]),
            .main_req   (main_req[s]),
            .rail_uv    (rail_uv[s*RAILS +: RAILS]),
            .oc_fast    (oc_fast[s]),
            .oc_slow    (oc_slow[s]),
            .slot_hot   (slot_hot[s]),
            .die_hot    (die_hot),
            .fault      (fault[s]),
            .fault_rise (fault_rise[s]),
            .aux_en     (aux_en[s]),
            .main_en    (main_en[s])
        );

        p_int_follows_fault_r12: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fault[s]) |-> int_q);
    end

    always_comb begin
        if (|fault_rise)  int_d = 1'b1;
        else if (int_ack) int_d = 1'b0;
        else              int_d = int_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) int_q <= 1'b0;
        else        int_q <= int_d;
    end

    assign fault_n = ~fault;
    assign int_n   = ~int_q;

    p_int_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
        int_q && !int_ack |=> int_q);
endmodule

// File: tb/hp_slot_supervisor_tb.sv
module hp_slot_supervisor_tb;
    localparam int NS = 2;
    localparam int RL = 5;
    localparam int PC = 20;
    localparam int FC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0] aux_req = '0, main_req = '0, oc_fast = '0, oc_slow = '0, slot_hot = '0;
    logic [NS*RL-1:0] rail_uv = '0;
    logic die_hot = 1'b0, int_ack = 1'b0;
    logic [NS-1:0] aux_en, main_en, fault_n;
    logic int_n, por_done;

    int n_chk = 0, n_bad = 0, cyc = 0;

    // reference state, derived from the requirements
    int  m_pcnt;
    bit  m_por, m_int;
    bit  m_fault[NS], m_arm[NS], m_aux[NS], m_main[NS];
    int  m_fcnt[NS];

    always #10 clk = ~clk;

    hp_slot_supervisor #(.NUM_SLOTS(NS), .RAILS(RL), .POR_CYCLES(PC), .FILT_CYCLES(FC)) u_dut (
        .clk(clk), .rst_n(rst_n), .aux_req(aux_req), .main_req(main_req), .rail_uv(rail_uv),
        .oc_fast(oc_fast), .oc_slow(oc_slow), .slot_hot(slot_hot), .die_hot(die_hot),
        .int_ack(int_ack), .aux_en(aux_en), .main_en(main_en), .fault_n(fault_n),
        .int_n(int_n), .por_done(por_done)
    );

    function automatic bit slot_uv(int s);
        return |rail_uv[s*RL +: RL];
    endfunction

    task automatic model_reset();
        m_pcnt = 0; m_por = 0; m_int = 0;
        for (int s = 0; s < NS; s++) begin
            m_fault[s] = 0; m_arm[s] = 0; m_aux[s] = 0; m_main[s] = 0; m_fcnt[s] = FC;
        end
    endtask

    task automatic model_edge();
        bit rise = 0;
        bit nf;
        bit exp_slow;
        for (int s = 0; s < NS; s++) begin
            exp_slow = oc_slow[s] && (m_fcnt[s] == 0);                       // R4
            nf = (aux_req[s] | main_req[s]) && m_por &&                       // R1, R8
                 (m_fault[s] | slot_uv(s) | oc_fast[s] | exp_slow |           // R2, R3, R7
                  (oc_slow[s] & slot_hot[s]) | die_hot);                      // R5, R6
            if (nf && !m_fault[s]) rise = 1;
            m_aux[s]  = aux_req[s] && m_arm[s] && !nf;                        // R9, R11
            m_main[s] = main_req[s] && m_por && !slot_uv(s) && !nf;           // R10, R11
            m_arm[s]  = m_arm[s] | (m_por & !aux_req[s]);
            m_fault[s] = nf;
            if (!oc_slow[s])       m_fcnt[s] = FC;
            else if (m_fcnt[s] > 0) m_fcnt[s]--;
        end
        if (rise)         m_int = 1;                                          // R12
        else if (int_ack) m_int = 0;
        if (!m_por) begin
            m_por = (m_pcnt == PC - 1);                                       // R8
            m_pcnt++;
        end
    endtask

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic compare_all();
        for (int s = 0; s < NS; s++) begin
            chk($sformatf("R1/R7 fault_n[%0d]", s), fault_n[s], !m_fault[s]);
            chk($sformatf("R9 aux_en[%0d]", s), aux_en[s], m_aux[s]);
            chk($sformatf("R10 main_en[%0d]", s), main_en[s], m_main[s]);
        end
        chk("R12 int_n", int_n, !m_int);
        chk("R8 por_done", por_done, m_por);
    endtask

    task automatic tick();
        @(posedge clk);
        cyc++;
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic clear_inputs();
        aux_req = '0; main_req = '0; oc_fast = '0; oc_slow = '0; slot_hot = '0;
        rail_uv = '0; die_hot = 0; int_ack = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        compare_all();
        chk("R8 reset fault_n", fault_n, 2'b11);
        chk("R8 reset int_n", int_n, 1);
        rst_n = 1;
    endtask

    initial begin
        while (cyc < 190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected <190000 cycles", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        clear_inputs();
        @(negedge clk);
        do_reset();

        // R8 and R3: fast trip held from reset on; nothing before POR
        main_req[0] = 1; oc_fast[0] = 1;
        ticks(PC - 1);
        chk("R8 por_done early", por_done, 0);
        chk("R8 no fault before por", fault_n[0], 1);
        tick();
        chk("R8 por_done at end", por_done, 1);
        chk("R8 fault waits one edge", fault_n[0], 1);
        tick();
        chk("R3 fast trip fault", fault_n[0], 0);
        chk("R11 main off on fault", main_en[0], 0);
        chk("R12 int on fault", int_n, 0);
        int_ack = 1; tick(); int_ack = 0;
        chk("R12 ack clears int", int_n, 1);
        oc_fast[0] = 0; tick();
        chk("R7 latched after cond clears", fault_n[0], 0);
        aux_req[0] = 1; main_req[0] = 0; tick();
        chk("R7 latched with one request", fault_n[0], 0);
        aux_req[0] = 0; tick();
        chk("R1 both requests dropped", fault_n[0], 1);

        // R1: condition without request
        oc_fast[1] = 1; ticks(2);
        chk("R1 no request no fault", fault_n[1], 1);
        oc_fast[1] = 0;

        // R9: armed after por with request low
        aux_req[0] = 1; tick();
        chk("R9 aux_en on", aux_en[0], 1);
        aux_req[0] = 0;

        // R10 and R2
        main_req[1] = 1; tick();
        chk("R10 main_en on", main_en[1], 1);
        rail_uv[1*RL + 2] = 1; tick();
        chk("R2 uv fault", fault_n[1], 0);
        chk("R11 main off on uv fault", main_en[1], 0);
        clear_inputs(); tick();

        // R4: slow filter expiry
        main_req[1] = 1; tick();
        oc_slow[1] = 1; ticks(FC);
        chk("R4 no fault inside window", fault_n[1], 1);
        tick();
        chk("R4 fault after window", fault_n[1], 0);
        clear_inputs(); tick();
        main_req[1] = 1; oc_slow[1] = 1; ticks(FC - 1);
        oc_slow[1] = 0; tick();
        oc_slow[1] = 1; ticks(FC);
        chk("R4 window reloaded", fault_n[1], 1);
        tick();
        chk("R4 fault after reloaded window", fault_n[1], 0);
        clear_inputs(); tick();

        // R5: slow trip while hot
        main_req[0] = 1; oc_slow[0] = 1; slot_hot[0] = 1; tick();
        chk("R5 slow trip hot", fault_n[0], 0);
        clear_inputs(); tick();

        // R6: global over-temperature
        main_req = 2'b11; die_hot = 1; tick();
        chk("R6 global hot slot0", fault_n[0], 0);
        chk("R6 global hot slot1", fault_n[1], 0);
        clear_inputs(); tick();

        // R9: request held through POR is not honoured
        aux_req[1] = 1;
        do_reset();
        ticks(PC + 3);
        chk("R9 held request blocked", aux_en[1], 0);
        aux_req[1] = 0; tick();
        aux_req[1] = 1; tick();
        chk("R9 re-raised request", aux_en[1], 1);

        // random phase against the reference
        for (int i = 0; i < 4000; i++) begin
            for (int s = 0; s < NS; s++) begin
                if ($urandom_range(15) == 0) aux_req[s]  = ~aux_req[s];
                if ($urandom_range(15) == 0) main_req[s] = ~main_req[s];
                oc_fast[s]  = ($urandom_range(47) == 0);
                if ($urandom_range(9) == 0) oc_slow[s] = ~oc_slow[s];
                slot_hot[s] = ($urandom_range(19) == 0);
            end
            for (int b = 0; b < NS*RL; b++) rail_uv[b] = ($urandom_range(299) == 0);
            die_hot = ($urandom_range(99) == 0);
            int_ack = ($urandom_range(5) == 0);
            tick();
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule